// File: doc/BRIEF.md
# Compare-Driven Periodic Timer

This block is an up-counting timer with a programmable clock divider. A single mode bit picks one of two counting schemes. In free-running mode the counter runs through its whole range and rolls over from all-ones to zero. In clear-on-match mode the counter returns to zero on the tick after it equals compare register A, so register A sets the period.

Three event sources each set their own sticky flag: the all-ones (overflow) value, a match on compare A, and a match on compare B. In clear-on-match mode the counter rolls back at compare A, not at all-ones, so the overflow flag never sets unless compare A itself is all-ones. Software that wants a periodic interrupt in that mode uses the compare-A event. Each flag drives an interrupt line through its own enable bit. Software clears a flag by writing a one to it. All registers sit behind a single-cycle parallel write port with a combinational read mux.

Top module: `tmr_ctc_timer`

## Requirements
- R1: After reset every register reads zero and all three interrupt outputs are low.
- R2: With mode bit 0 (free-running), the counter adds one on each divider tick and goes from all-ones to zero. Compare A has no effect on the count sequence.
- R3: Flag bit 0 (overflow) sets on a tick taken while the counter holds all-ones. In clear-on-match mode with compare A below all-ones it never sets.
- R4: With mode bit 1 (clear-on-match), the counter goes to zero on the tick taken while it equals compare A. With divide-by-1 and compare A = N-1, the period is exactly N clock cycles.
- R5: Flag bit 1 sets on every tick taken while the counter equals compare A, in either mode.
- R6: Flag bit 2 sets on every tick taken while the counter equals compare B. In clear-on-match mode this happens once per period when B is at or below compare A, and never when B is above it.
- R7: Control bits [3:1] select the divider. Codes 1 to 5 tick every 1, 8, 64, 256 and 1024 cycles. Codes 0, 6 and 7 stop the counter. Control bit 0 is the mode bit.
- R8: Writing a one to a flag bit clears it, and writing a zero leaves it unchanged. A set event in the same cycle as its clear wins, so the flag stays set.
- R9: Each interrupt output is high exactly when its flag and its enable bit are both set. Enable bit 0 gates overflow, bit 1 gates compare A and bit 2 gates compare B, each independently.
- R10: A write to the count register loads the value on that clock edge. No flag sets on that edge, even if the old count matched.
- R11: The address map is: 0 control, 1 count, 2 compare A, 3 compare B, 4 enables, 5 flags. Addresses 6 and 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block synchronizes its release |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Combinational read data for `addr` |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_cmpa | output | 1 | Compare-A interrupt |
| irq_cmpb | output | 1 | Compare-B interrupt |

## Verification
The bench builds the block with an 8-bit counter, so all-ones is 255. That keeps a full free-running rollover, and a clear-on-match period with compare A set to all-ones, within a few hundred cycles.

Against that narrow counter the bench sweeps every compare-A value from 1 to 12 against every compare-B value from 0 to 14. It checks the count and the flag word against closed-form expectations on every cycle of three periods. The sweep covers compare B below, equal to and above compare A.

The divider is left at its natural 10-bit width, so all five division ratios can be timed in full.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W   = 3;
  localparam int PS_SEL_W = 3;
  localparam int N_EV     = 3;

  // event / flag / enable bit positions
  localparam int EV_OVF  = 0;
  localparam int EV_CMPA = 1;
  localparam int EV_CMPB = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPA  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMPB  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_IEN   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_FLAG  = 3'd5;

  typedef enum logic [PS_SEL_W-1:0] {
    PS_STOP    = 3'd0,
    PS_DIV1    = 3'd1,
    PS_DIV8    = 3'd2,
    PS_DIV64   = 3'd3,
    PS_DIV256  = 3'd4,
    PS_DIV1024 = 3'd5
  } ps_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PS_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PS_SEL_W-1:0] sel,
  output logic                tick
);
  logic [PS_W-1:0] div_q, div_d;
  logic [PS_W-1:0] mask;
  logic            run;

  // free-running divider; every ratio is a power of two dividing 2**PS_W
  always_comb begin
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  always_comb begin
    run  = 1'b1;
    mask = '0;
    case (sel)
      PS_DIV1:    mask = '0;
      PS_DIV8:    mask = PS_W'((1 << 3) - 1);
      PS_DIV64:   mask = PS_W'((1 << 6) - 1);
      PS_DIV256:  mask = PS_W'((1 << 8) - 1);
      PS_DIV1024: mask = PS_W'((1 << 10) - 1);
      default:    run  = 1'b0;
    endcase
    tick = run && ((div_q & mask) == mask);
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ctc,
  input  logic [W-1:0] top,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld) begin
      cnt_d = ld_val;
    end else if (tick) begin
      if (ctc && (cnt_q == top)) cnt_d = '0;
      else                       cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q, f_d;
    // a set in the clearing cycle wins
    always_comb f_d = set[i] | (f_q & ~clr[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= f_d;
    end
    assign q[i] = f_q;
  end
endmodule

// File: rtl/tmr_ctc_timer.sv
module tmr_ctc_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq_ovf,
  output logic              irq_cmpa,
  output logic              irq_cmpb
);
  localparam int               CTRL_W  = 1 + PS_SEL_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  cmpa_q, cmpa_d, cmpb_q, cmpb_d;
  logic [N_EV-1:0]   en_q, en_d;
  logic              wr_ctrl, wr_cmpa, wr_cmpb, wr_ien, wr_flag, cnt_wr;

  always_comb begin
    wr_ctrl = wr_en && (addr == ADDR_CTRL);
    cnt_wr  = wr_en && (addr == ADDR_COUNT);
    wr_cmpa = wr_en && (addr == ADDR_CMPA);
    wr_cmpb = wr_en && (addr == ADDR_CMPB);
    wr_ien  = wr_en && (addr == ADDR_IEN);
    wr_flag = wr_en && (addr == ADDR_FLAG);
  end

  always_comb begin
    ctrl_d = ctrl_q;
    cmpa_d = cmpa_q;
    cmpb_d = cmpb_q;
    en_d   = en_q;
    if (wr_ctrl) ctrl_d = wr_data[CTRL_W-1:0];
    if (wr_cmpa) cmpa_d = wr_data;
    if (wr_cmpb) cmpb_d = wr_data;
    if (wr_ien)  en_d   = wr_data[N_EV-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      en_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cmpa_q <= cmpa_d;
      cmpb_q <= cmpb_d;
      en_q   <= en_d;
    end
  end

  logic                ctc_mode;
  logic [PS_SEL_W-1:0] ps_sel;
  logic                tick;
  assign ctc_mode = ctrl_q[0];
  assign ps_sel   = ctrl_q[CTRL_W-1:1];

  tmr_prescaler #(.PS_W(PS_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .sel   (ps_sel),
    .tick  (tick)
  );

  logic [CNT_W-1:0] cnt_q;
  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick),
    .ctc    (ctc_mode),
    .top    (cmpa_q),
    .ld     (cnt_wr),
    .ld_val (wr_data),
    .cnt    (cnt_q)
  );

  // matches look at the pre-increment value; a count load masks them
  logic            evt_ok;
  logic [N_EV-1:0] ev_set, flag_clr, flags_q;
  always_comb begin
    evt_ok           = tick && !cnt_wr;
    ev_set[EV_OVF]   = evt_ok && (cnt_q == CNT_MAX);
    ev_set[EV_CMPA]  = evt_ok && (cnt_q == cmpa_q);
    ev_set[EV_CMPB]  = evt_ok && (cnt_q == cmpb_q);
    flag_clr         = wr_flag ? wr_data[N_EV-1:0] : '0;
  end

  tmr_flags #(.N(N_EV)) u_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (ev_set),
    .clr   (flag_clr),
    .q     (flags_q)
  );

  assign irq_ovf  = flags_q[EV_OVF]  & en_q[EV_OVF];
  assign irq_cmpa = flags_q[EV_CMPA] & en_q[EV_CMPA];
  assign irq_cmpb = flags_q[EV_CMPB] & en_q[EV_CMPB];

  always_comb begin
    rd_data = '0;
    case (addr)
      ADDR_CTRL:  rd_data = CNT_W'(ctrl_q);
      ADDR_COUNT: rd_data = cnt_q;
      ADDR_CMPA:  rd_data = cmpa_q;
      ADDR_CMPB:  rd_data = cmpb_q;
      ADDR_IEN:   rd_data = CNT_W'(en_q);
      ADDR_FLAG:  rd_data = CNT_W'(flags_q);
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_ctc_checker.sv
module tmr_ctc_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         cnt_wr,
  input logic         ctc,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmpa,
  input logic [W-1:0] wr_data,
  input logic [2:0]   flags,
  input logic [2:0]   clr,
  input logic [2:0]   en,
  input logic         irq_ovf,
  input logic         irq_cmpa,
  input logic         irq_cmpb
);
  localparam logic [W-1:0] MAXV = '1;

  assert_normal_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && !ctc) |=> (cnt == W'($past(cnt) + 1'b1)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> ($past(cnt) == MAXV));

  assert_ctc_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && ctc && (cnt == cmpa)) |=> (cnt == '0));

  assert_cmpa_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && (cnt == cmpa)) |=> flags[1]);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

  assert_irq_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ovf) |-> ($rose(flags[0]) || $rose(en[0])));

  assert_irq_cmpa_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_cmpa) |-> ($rose(flags[1]) || $rose(en[1])));

  assert_irq_cmpb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_cmpb) |-> ($rose(flags[2]) || $rose(en[2])));

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> ((cnt == $past(wr_data)) && ((flags & ~$past(flags)) == 3'b000)));
endmodule

bind tmr_ctc_timer tmr_ctc_checker #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .tick     (tick),
  .cnt_wr   (cnt_wr),
  .ctc      (ctc_mode),
  .cnt      (cnt_q),
  .cmpa     (cmpa_q),
  .wr_data  (wr_data),
  .flags    (flags_q),
  .clr      (flag_clr),
  .en       (en_q),
  .irq_ovf  (irq_ovf),
  .irq_cmpa (irq_cmpa),
  .irq_cmpb (irq_cmpb)
);

// File: tb/tmr_ctc_timer_tb.sv
module tmr_ctc_timer_tb;
  import tmr_pkg::*;

  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [2:0]   addr;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data;
  logic         irq_ovf, irq_cmpa, irq_cmpb;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tmr_ctc_timer #(.CNT_W(W)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq_ovf  (irq_ovf),
    .irq_cmpa (irq_cmpa),
    .irq_cmpb (irq_cmpb)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    addr    = a;
    wr_data = W'(d);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output int d);
    addr = a;
    #1 d = int'(rd_data);
  endtask

  task automatic setup(input int ctc, input int sel, input int start,
                       input int a, input int b, input int en);
    wr(ADDR_CTRL, 0);
    wr(ADDR_FLAG, 7);
    wr(ADDR_CMPA, a);
    wr(ADDR_CMPB, b);
    wr(ADDR_IEN, en);
    wr(ADDR_COUNT, start);
    wr(ADDR_CTRL, sel * 2 + ctc);
  endtask

  // divide-by-1 window; sample k shows the state after the k-th edge
  task automatic run_window(input int ctc, input int start, input int a,
                            input int b, input int en, input int n);
    setup(ctc, 1, start, a, b, en);
    for (int k = 0; k <= n; k++) begin
      int fl, c, cb, ex, ec, iv;
      @(negedge clk);
      wr_en = 1'b0;
      peek(ADDR_COUNT, c);
      peek(ADDR_FLAG, fl);
      ex = 0;
      if (ctc != 0) ec = k % (a + 1);
      else          ec = (start + k) % (MAXV + 1);
      if (k >= 1) begin
        if (ctc != 0) cb = (k - 1) % (a + 1);
        else          cb = (start + k - 1) % (MAXV + 1);
        if (cb == MAXV) ex = ex | 1;
        if (cb == a)    ex = ex | 2;
        if (cb == b)    ex = ex | 4;
      end
      check_eq(ctc != 0 ? "R4 ctc count" : "R2 normal count", c, ec);
      check_eq("R3 R5 R6 flag word", fl, ex);
      iv = {29'd0, irq_cmpb, irq_cmpa, irq_ovf};
      check_eq("R9 irq gating", iv, ex & en);
      if (fl != 0) begin
        wr_en   = 1'b1;
        wr_data = W'(fl);
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic presc_check(input int sel, input int d);
    int last, prev, changes;
    last = -1; prev = 0; changes = 0;
    setup(0, sel, 0, 200, 200, 0);
    for (int k = 0; k <= 3 * d + 1; k++) begin
      int c;
      @(negedge clk);
      peek(ADDR_COUNT, c);
      if (c != prev) begin
        if (last >= 0) check_eq("R7 tick interval", k - last, d);
        last = k;
        prev = c;
        changes++;
      end
    end
    check_eq("R7 tick count at least 3", (changes >= 3) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      misses++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int v;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      peek(3'(a), v);
      check_eq("R1 reset register", v, 0);
    end
    check_eq("R1 reset irq", int'({irq_cmpb, irq_cmpa, irq_ovf}), 0);

    // R11 register map
    wr(ADDR_CTRL, 13);
    wr(ADDR_COUNT, 8'h77);
    wr(ADDR_CMPA, 8'hA5);
    wr(ADDR_CMPB, 8'h3C);
    wr(ADDR_IEN, 8'hFF);
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'h11);
    @(negedge clk);
    peek(ADDR_CTRL, v);  check_eq("R11 ctrl readback", v, 13);
    peek(ADDR_COUNT, v); check_eq("R11 count readback", v, 8'h77);
    peek(ADDR_CMPA, v);  check_eq("R11 cmpa readback", v, 8'hA5);
    peek(ADDR_CMPB, v);  check_eq("R11 cmpb readback", v, 8'h3C);
    peek(ADDR_IEN, v);   check_eq("R11 enable readback", v, 7);
    peek(3'd6, v);       check_eq("R11 unmapped 6", v, 0);
    peek(3'd7, v);       check_eq("R11 unmapped 7", v, 0);
    peek(ADDR_FLAG, v);  check_eq("R11 flags untouched", v, 0);

    // R2 R3 R5 free-running with rollover
    run_window(0, 250, 5, 7, 5, 300);
    run_window(0, 0, 200, 100, 7, 270);

    // R4 R6 clear-on-match sweep; compare B below, at and above TOP
    for (int a = 1; a <= 12; a++)
      for (int b = 0; b <= 14; b++)
        run_window(1, 0, a, b, (a + b) % 8, 3 * (a + 1) + 2);

    // R3 TOP just below MAX: no overflow; TOP at MAX: overflow
    run_window(1, 0, MAXV - 1, MAXV - 1, 7, 2 * MAXV + 4);
    run_window(1, 0, MAXV, 3, 7, MAXV + 4);

    // R7 divider ratios and stop codes
    presc_check(1, 1);
    presc_check(2, 8);
    presc_check(3, 64);
    presc_check(4, 256);
    presc_check(5, 1024);
    for (int s = 0; s < 8; s++) begin
      if (s == 0 || s == 6 || s == 7) begin
        setup(0, s, 5, 9, 9, 0);
        repeat (40) @(negedge clk);
        peek(ADDR_COUNT, v);
        check_eq("R7 stopped count", v, 5);
      end
    end

    // R8 set wins over clear: B event at the 5th edge, clear written there
    setup(1, 1, 0, 9, 4, 0);
    repeat (4) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_FLAG; wr_data = W'(4);
    @(posedge clk);
    #1 wr_en = 1'b0;
    @(negedge clk);
    peek(ADDR_FLAG, v);
    check_eq("R8 set beats clear", v, 4);
    wr(ADDR_FLAG, 0);
    @(negedge clk);
    peek(ADDR_FLAG, v);
    check_eq("R8 writing zero keeps flag", v, 4);

    // R10 load on the matching cycle suppresses compare B
    setup(1, 1, 2, 9, 3, 7);
    @(negedge clk);
    @(negedge clk);
    peek(ADDR_COUNT, v);
    check_eq("R10 pre-load count", v, 3);
    wr_en = 1'b1; addr = ADDR_COUNT; wr_data = W'(7);
    @(posedge clk);
    #1 wr_en = 1'b0;
    @(negedge clk);
    peek(ADDR_COUNT, v);
    check_eq("R10 loaded count", v, 7);
    peek(ADDR_FLAG, v);
    check_eq("R10 no flag on load edge", v, 0);
    check_eq("R10 irq quiet", int'(irq_cmpb), 0);
    @(negedge clk);
    peek(ADDR_COUNT, v);
    check_eq("R10 counting resumes", v, 8);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule